// File: doc/BRIEF.md
# DS3 Overhead Error Injector

This block sits on the serial transmit path of a DS3 framer, after the overhead bits have been written. Each cycle it receives one bit of the framed M-frame stream. With that bit come its position: the subframe index, the block index inside the subframe, and a flag that marks the bit as overhead. The block inverts chosen overhead bits so that a far end sees framing faults, P-bit parity errors, C-bit parity errors or far-end block errors. Payload bits and all other overhead bits pass through unchanged, delayed by one register.

There are four independent error types: framing, P-bit parity, C-bit parity and FEBE. Each type has a single-shot request pulse and a continuous-mode level. A single-shot request waits for the next M-frame boundary. It then corrupts one M-frame, or two consecutive M-frames for the two long framing modes. When it finishes, the type raises a one-cycle acknowledge. Continuous mode corrupts every M-frame for as long as it is held.

Top module: `ds3_err_inj`

## Requirements
- R1: While rst_ni is low, data_o and all four acknowledge outputs are 0.
- R2: data_o equals data_i delayed by exactly one cycle, except for bits that this block deliberately inverts. Bits with oh_i low are never inverted.
- R3: An M-frame boundary is the input cycle with oh_i=1, sub_i=0 and blk_i=0. A single-shot request is applied at the first boundary that comes after the cycle of the request pulse, so a pulse in a boundary cycle is applied at the following boundary. The boundary bit itself is never inverted.
- R4: frm_mode_i is sampled at the boundary where insertion begins. Mode 0 inverts only the first F bit of subframe 0 (sub_i=0, blk_i=1), in one M-frame. Mode 1 inverts only the first M bit (sub_i=4, blk_i=0), in one M-frame.
- R5: Mode 2 inverts all four F bits of subframe 0 (sub_i=0, blk_i odd) in each of two consecutive M-frames. Mode 3 inverts the first M bit in each of two consecutive M-frames.
- R6: A P-bit parity error inverts both P bits (blk_i=0 with sub_i=2 and sub_i=3) of one M-frame.
- R7: A C-bit parity error inverts the three C bits of subframe index 2 (blk_i=2, 4, 6) of one M-frame.
- R8: A FEBE error inverts the three C bits of subframe index 3 (blk_i=2, 4, 6) of one M-frame.
- R9: Each single-shot insertion produces exactly one one-cycle acknowledge pulse. The pulse appears in the cycle after the boundary that closes the last corrupted M-frame.
- R10: Any number of request pulses of one type that arrive before that type's next boundary are merged into one insertion with one acknowledge.
- R11: While a type's continuous input is high at a boundary, the M-frame that starts there is corrupted and no acknowledge is given. Request pulses of that type are ignored while continuous mode is high. Corruption stops at the first boundary where continuous mode is low.
- R12: The four types are independent. Several types may corrupt the same M-frame, and their acknowledges may fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Framed serial DS3 bit |
| oh_i | input | 1 | Current bit is an overhead bit |
| sub_i | input | 3 | Subframe index, 0 to 6 |
| blk_i | input | 3 | Block index inside the subframe, 0 to 7 |
| frm_mode_i | input | 2 | Framing error kind: 0 F bit, 1 M bit, 2 subframe, 3 multiframe |
| frm_req_i | input | 1 | Single-shot framing error request |
| frm_cont_i | input | 1 | Continuous framing error |
| par_req_i | input | 1 | Single-shot P-bit parity error request |
| par_cont_i | input | 1 | Continuous P-bit parity error |
| cbp_req_i | input | 1 | Single-shot C-bit parity error request |
| cbp_cont_i | input | 1 | Continuous C-bit parity error |
| febe_req_i | input | 1 | Single-shot FEBE error request |
| febe_cont_i | input | 1 | Continuous FEBE error |
| data_o | output | 1 | Serial bit after error insertion |
| frm_ack_o | output | 1 | Framing insertion complete |
| par_ack_o | output | 1 | P-bit insertion complete |
| cbp_ack_o | output | 1 | C-bit parity insertion complete |
| febe_ack_o | output | 1 | FEBE insertion complete |

## Verification
Two events can fall in the same cycle. The first is a request pulse arriving exactly on an M-frame boundary, where the block must arm the request rather than activate it. The bench provokes this by pulsing a FEBE request in the boundary bit. It then requires the frame that starts there to be clean and the following frame to be corrupted. The second is two types finishing at the same boundary. The bench requests P-bit and C-bit errors in the same bit, then requires both sets of bits to be inverted in one frame and both acknowledges to appear in the same cycle.

// File: rtl/ds3_err_pkg.sv
package ds3_err_pkg;
  localparam int SUB_W   = 3;
  localparam int BLK_W   = 3;
  localparam int NUM_SUB = 7;
  localparam int NUM_BLK = 8;
  localparam int M_FIRST = 4;   // subframe holding the first M bit
  localparam int P_FIRST = 2;   // subframes holding the P bits
  localparam int CP_SUB  = 2;
  localparam int FB_SUB  = 3;
  localparam int NCH     = 4;
  localparam int CH_FRM  = 0;
  localparam int CH_PAR  = 1;
  localparam int CH_CBP  = 2;
  localparam int CH_FEBE = 3;
  localparam int SEL_W   = 2;
  localparam int IDX_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    FRM_FBIT = 2'd0,
    FRM_MBIT = 2'd1,
    FRM_SUBF = 2'd2,
    FRM_MULT = 2'd3
  } frm_mode_e;

  typedef struct packed {
    logic             sof;
    logic             f;
    logic [IDX_W-1:0] f_idx;
    logic             f_sub0;
    logic             m;
    logic [IDX_W-1:0] m_idx;
    logic             p;
    logic             cbp;
    logic             febe;
  } oh_cls_t;
endpackage

// File: rtl/ds3_oh_decode.sv
module ds3_oh_decode
  import ds3_err_pkg::*;
(
  input  logic             oh_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [BLK_W-1:0] blk_i,
  output oh_cls_t          cls_o
);
  logic             blk0;
  logic             c_pos;
  logic [SUB_W-1:0] m_off;

  assign blk0  = (blk_i == '0);
  assign c_pos = !blk0 && !blk_i[0];
  assign m_off = sub_i - SUB_W'(M_FIRST);

  always_comb begin
    cls_o        = '0;
    cls_o.sof    = oh_i && blk0 && (sub_i == '0);
    cls_o.f      = oh_i && blk_i[0];
    cls_o.f_idx  = blk_i[BLK_W-1:1];
    cls_o.f_sub0 = oh_i && blk_i[0] && (sub_i == '0);
    cls_o.m      = oh_i && blk0 && (sub_i >= SUB_W'(M_FIRST)) && (sub_i < SUB_W'(NUM_SUB));
    cls_o.m_idx  = m_off[IDX_W-1:0];
    cls_o.p      = oh_i && blk0 && ((sub_i == SUB_W'(P_FIRST)) || (sub_i == SUB_W'(P_FIRST + 1)));
    cls_o.cbp    = oh_i && c_pos && (sub_i == SUB_W'(CP_SUB));
    cls_o.febe   = oh_i && c_pos && (sub_i == SUB_W'(FB_SUB));
  end
endmodule

// File: rtl/ds3_err_chan.sv
module ds3_err_chan #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             req_i,
  input  logic             cont_i,
  input  logic             span2_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             act_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             ack_o
);
  logic             pend_q, act_q, one_q, left_q, ack_q;
  logic [SEL_W-1:0] sel_q;
  logic             req_ok;

  assign req_ok = req_i && !cont_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      one_q  <= 1'b0;
      left_q <= 1'b0;
      ack_q  <= 1'b0;
      sel_q  <= '0;
    end else begin
      ack_q <= 1'b0;
      if (sof_i) begin
        if (act_q && one_q && !left_q) ack_q <= 1'b1;
        if (act_q && left_q) begin
          // second frame of a two-frame insertion
          left_q <= 1'b0;
          pend_q <= pend_q || req_ok;
        end else if (cont_i) begin
          act_q  <= 1'b1;
          one_q  <= 1'b0;
          left_q <= 1'b0;
          sel_q  <= sel_i;
          pend_q <= 1'b0;
        end else if (pend_q) begin
          act_q  <= 1'b1;
          one_q  <= 1'b1;
          left_q <= span2_i;
          sel_q  <= sel_i;
          pend_q <= req_ok;
        end else begin
          act_q  <= 1'b0;
          one_q  <= 1'b0;
          pend_q <= req_ok;
        end
      end else if (req_ok) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign act_o = act_q;
  assign sel_o = sel_q;
  assign ack_o = ack_q;
endmodule

// File: rtl/ds3_err_mask.sv
module ds3_err_mask
  import ds3_err_pkg::*;
(
  input  oh_cls_t          cls_i,
  input  logic [NCH-1:0]   act_i,
  input  logic [SEL_W-1:0] frm_sel_i,
  output logic             flip_o
);
  logic frm_hit;

  always_comb begin
    unique case (frm_mode_e'(frm_sel_i))
      FRM_FBIT: frm_hit = cls_i.f_sub0 && (cls_i.f_idx == '0);
      FRM_MBIT: frm_hit = cls_i.m && (cls_i.m_idx == '0);
      FRM_SUBF: frm_hit = cls_i.f_sub0;
      FRM_MULT: frm_hit = cls_i.m && (cls_i.m_idx == '0);
      default:  frm_hit = 1'b0;
    endcase
  end

  assign flip_o = (act_i[CH_FRM]  && frm_hit)   ||
                  (act_i[CH_PAR]  && cls_i.p)   ||
                  (act_i[CH_CBP]  && cls_i.cbp) ||
                  (act_i[CH_FEBE] && cls_i.febe);
endmodule

// File: rtl/ds3_err_inj.sv
module ds3_err_inj
  import ds3_err_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic             oh_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [SEL_W-1:0] frm_mode_i,
  input  logic             frm_req_i,
  input  logic             frm_cont_i,
  input  logic             par_req_i,
  input  logic             par_cont_i,
  input  logic             cbp_req_i,
  input  logic             cbp_cont_i,
  input  logic             febe_req_i,
  input  logic             febe_cont_i,
  output logic             data_o,
  output logic             frm_ack_o,
  output logic             par_ack_o,
  output logic             cbp_ack_o,
  output logic             febe_ack_o
);
  oh_cls_t          cls;
  logic [NCH-1:0]   req, cont, span2, act, ack;
  logic [SEL_W-1:0] sel_in  [NCH];
  logic [SEL_W-1:0] sel_out [NCH];
  logic             flip;
  logic             data_q;

  ds3_oh_decode u_dec (
    .oh_i  (oh_i),
    .sub_i (sub_i),
    .blk_i (blk_i),
    .cls_o (cls)
  );

  assign req  = {febe_req_i, cbp_req_i, par_req_i, frm_req_i};
  assign cont = {febe_cont_i, cbp_cont_i, par_cont_i, frm_cont_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g == CH_FRM) begin : g_frm
      assign sel_in[g] = frm_mode_i;
      assign span2[g]  = (frm_mode_i == FRM_SUBF) || (frm_mode_i == FRM_MULT);
    end else begin : g_par
      assign sel_in[g] = '0;
      assign span2[g]  = 1'b0;
    end

    ds3_err_chan #(.SEL_W(SEL_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sof_i   (cls.sof),
      .req_i   (req[g]),
      .cont_i  (cont[g]),
      .span2_i (span2[g]),
      .sel_i   (sel_in[g]),
      .act_o   (act[g]),
      .sel_o   (sel_out[g]),
      .ack_o   (ack[g])
    );
  end

  ds3_err_mask u_mask (
    .cls_i     (cls),
    .act_i     (act),
    .frm_sel_i (sel_out[CH_FRM]),
    .flip_o    (flip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= 1'b0;
    else         data_q <= data_i ^ flip;
  end

  assign data_o     = data_q;
  assign frm_ack_o  = ack[CH_FRM];
  assign par_ack_o  = ack[CH_PAR];
  assign cbp_ack_o  = ack[CH_CBP];
  assign febe_ack_o = ack[CH_FEBE];
endmodule

// File: rtl/ds3_err_inj_chk.sv
module ds3_err_inj_chk
  import ds3_err_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             data_i,
  input logic             oh_i,
  input logic [SUB_W-1:0] sub_i,
  input logic [BLK_W-1:0] blk_i,
  input logic             data_o,
  input logic             frm_ack_o,
  input logic             par_ack_o,
  input logic             cbp_ack_o,
  input logic             febe_ack_o
);
  logic sof, any_ack;
  assign sof     = oh_i && (sub_i == '0) && (blk_i == '0);
  assign any_ack = frm_ack_o || par_ack_o || cbp_ack_o || febe_ack_o;

  // R2
  payload_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oh_i |=> (data_o == $past(data_i)));

  // R3
  sof_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof |=> (data_o == $past(data_i)));

  // R9
  ack_after_sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ack |-> $past(sof));

  // R9
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ack |=> !any_ack);

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!data_o && !any_ack));
endmodule

bind ds3_err_inj ds3_err_inj_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .data_i     (data_i),
  .oh_i       (oh_i),
  .sub_i      (sub_i),
  .blk_i      (blk_i),
  .data_o     (data_o),
  .frm_ack_o  (frm_ack_o),
  .par_ack_o  (par_ack_o),
  .cbp_ack_o  (cbp_ack_o),
  .febe_ack_o (febe_ack_o)
);

// File: tb/ds3_err_inj_tb.sv
module ds3_err_inj_tb_top;
  localparam int PAY     = 4;
  localparam int BLK_LEN = PAY + 1;
  localparam int FRM_LEN = 7 * 8 * BLK_LEN;
  localparam int MAXF    = 128;
  localparam int NCLS    = 10;
  localparam int NTBL    = 7;
  // kind: 0..3 framing modes, 4 P, 5 C parity, 6 FEBE
  localparam int T_KIND [NTBL] = '{0, 1, 2, 3, 4, 5, 6};
  localparam int T_SPAN [NTBL] = '{1, 1, 2, 2, 1, 1, 1};
  localparam int T_FLIP [NTBL] = '{1, 1, 4, 1, 2, 3, 3};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic din = 1'b0, oh = 1'b0;
  logic [2:0] sub = '0, blk = '0;
  logic [1:0] frm_mode = '0;
  logic frm_req = 0, frm_cont = 0, par_req = 0, par_cont = 0;
  logic cbp_req = 0, cbp_cont = 0, febe_req = 0, febe_cont = 0;
  logic dout, frm_ack, par_ack, cbp_ack, febe_ack;

  int checks = 0, fails = 0;
  int gpos = 0;
  logic [15:0] lfsr = 16'hACE1;
  int cnt [MAXF][NCLS];
  int ack_cnt [4];
  int ack_pos [4];

  always #2.5 clk = ~clk;

  ds3_err_inj dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(din), .oh_i(oh), .sub_i(sub), .blk_i(blk),
    .frm_mode_i(frm_mode), .frm_req_i(frm_req), .frm_cont_i(frm_cont),
    .par_req_i(par_req), .par_cont_i(par_cont), .cbp_req_i(cbp_req), .cbp_cont_i(cbp_cont),
    .febe_req_i(febe_req), .febe_cont_i(febe_cont), .data_o(dout),
    .frm_ack_o(frm_ack), .par_ack_o(par_ack), .cbp_ack_o(cbp_ack), .febe_ack_o(febe_ack)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  // 0 payload, 1 F first of sub0, 2 other F of sub0, 3 F elsewhere,
  // 4 first M, 5 other M, 6 P, 7 C parity, 8 FEBE, 9 other overhead
  function automatic int cls_of(input int s, input int b, input bit o);
    if (!o) return 0;
    if (b % 2 == 1) return (s == 0) ? ((b == 1) ? 1 : 2) : 3;
    if (b == 0) begin
      if (s == 4) return 4;
      if (s > 4) return 5;
      if (s == 2 || s == 3) return 6;
      return 9;
    end
    if (s == 2) return 7;
    if (s == 3) return 8;
    return 9;
  endfunction

  function automatic int exp_c(input int kind, input int c);
    case (kind)
      0: return (c == 1) ? 1 : 0;
      1: return (c == 4) ? 1 : 0;
      2: return (c == 1) ? 1 : (c == 2) ? 3 : 0;
      3: return (c == 4) ? 1 : 0;
      4: return (c == 6) ? 2 : 0;
      5: return (c == 7) ? 3 : 0;
      6: return (c == 8) ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int kind);
    if (kind < 2) return "R4";
    if (kind < 4) return "R5";
    if (kind == 4) return "R6";
    if (kind == 5) return "R7";
    return "R8";
  endfunction

  task automatic step();
    int p, slot, c, fr;
    p    = gpos % FRM_LEN;
    slot = p / BLK_LEN;
    sub  = 3'(slot / 8);
    blk  = 3'(slot % 8);
    oh   = (p % BLK_LEN) == 0;
    din  = lfsr[0];
    @(posedge clk);
    #1;
    fr = gpos / FRM_LEN;
    c  = cls_of(slot / 8, slot % 8, oh);
    if ((dout ^ din) && fr < MAXF) cnt[fr][c]++;
    if (frm_ack)  begin ack_cnt[0]++; ack_pos[0] = gpos; end
    if (par_ack)  begin ack_cnt[1]++; ack_pos[1] = gpos; end
    if (cbp_ack)  begin ack_cnt[2]++; ack_pos[2] = gpos; end
    if (febe_ack) begin ack_cnt[3]++; ack_pos[3] = gpos; end
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    gpos++;
  endtask

  task automatic run_to(input int p);
    while (gpos % FRM_LEN != p) step();
  endtask

  task automatic run_frames_to(input int f);
    while (gpos < f * FRM_LEN) step();
  endtask

  task automatic clr_acks();
    for (int i = 0; i < 4; i++) begin ack_cnt[i] = 0; ack_pos[i] = -1; end
  endtask

  task automatic set_req(input int kind, input logic v);
    case (kind)
      0, 1, 2, 3: begin frm_mode = 2'(kind); frm_req = v; end
      4: par_req = v;
      5: cbp_req = v;
      default: febe_req = v;
    endcase
  endtask

  // compare a frame's flip classes against up to two active kinds (-1 = none)
  task automatic chk_frame(input int fr, input int ka, input int kb, input string r);
    int bad_c, act_v, exp_v;
    bad_c = -1; act_v = 0; exp_v = 0;
    for (int c = 0; c < NCLS; c++) begin
      int e;
      e = ((ka >= 0) ? exp_c(ka, c) : 0) + ((kb >= 0) ? exp_c(kb, c) : 0);
      if (cnt[fr][c] != e && bad_c < 0) begin bad_c = c; act_v = cnt[fr][c]; exp_v = e; end
    end
    if (bad_c >= 0) $display("  frame %0d class %0d mismatch", fr, bad_c);
    chk(bad_c < 0, r, act_v, exp_v);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin : main
    int k, ch;
    for (int f = 0; f < MAXF; f++)
      for (int c = 0; c < NCLS; c++) cnt[f][c] = 0;
    clr_acks();

    // R1 reset state
    repeat (4) @(posedge clk);
    #1;
    chk(dout == 1'b0, "R1 data", int'(dout), 0);
    chk({frm_ack, par_ack, cbp_ack, febe_ack} == 4'b0, "R1 ack",
        int'({frm_ack, par_ack, cbp_ack, febe_ack}), 0);
    rst_ni = 1'b1;

    // R2 idle frame passes untouched
    run_frames_to(1);
    chk_frame(0, -1, -1, "R2 idle");

    // table of single-shot requests
    for (int i = 0; i < NTBL; i++) begin
      run_to(100);
      k  = gpos / FRM_LEN;
      ch = (T_KIND[i] < 4) ? 0 : T_KIND[i] - 3;
      clr_acks();
      set_req(T_KIND[i], 1'b1);
      step();
      set_req(T_KIND[i], 1'b0);
      run_frames_to(k + 4);
      chk_frame(k, -1, -1, "R3 request frame clean");
      for (int j = 1; j <= 3; j++)
        chk_frame(k + j, (j <= T_SPAN[i]) ? T_KIND[i] : -1, -1, tag_of(T_KIND[i]));
      chk(cnt[k + 1][1] + cnt[k + 1][2] + cnt[k + 1][4] + cnt[k + 1][6] + cnt[k + 1][7] + cnt[k + 1][8]
          == T_FLIP[i], tag_of(T_KIND[i]),
          cnt[k + 1][1] + cnt[k + 1][2] + cnt[k + 1][4] + cnt[k + 1][6] + cnt[k + 1][7] + cnt[k + 1][8],
          T_FLIP[i]);
      chk(ack_cnt[ch] == 1, "R9 ack count", ack_cnt[ch], 1);
      chk(ack_pos[ch] == (k + 1 + T_SPAN[i]) * FRM_LEN, "R9 ack cycle", ack_pos[ch],
          (k + 1 + T_SPAN[i]) * FRM_LEN);
    end

    // R10 merge of two pulses
    run_to(50);
    k = gpos / FRM_LEN;
    clr_acks();
    cbp_req = 1; step(); cbp_req = 0;
    run_to(150);
    cbp_req = 1; step(); cbp_req = 0;
    run_frames_to(k + 3);
    chk_frame(k + 1, 5, -1, "R10 merged frame");
    chk_frame(k + 2, -1, -1, "R10 no second insertion");
    chk(ack_cnt[2] == 1, "R10 single ack", ack_cnt[2], 1);

    // R11 continuous P-bit errors
    run_to(100);
    k = gpos / FRM_LEN;
    clr_acks();
    par_cont = 1;
    run_frames_to(k + 2);
    run_to(100);
    par_req = 1; step(); par_req = 0;
    run_frames_to(k + 3);
    run_to(100);
    par_cont = 0;
    run_frames_to(k + 6);
    chk_frame(k + 1, 4, -1, "R11 cont frame 1");
    chk_frame(k + 2, 4, -1, "R11 cont frame 2");
    chk_frame(k + 3, 4, -1, "R11 cont frame 3");
    chk_frame(k + 4, -1, -1, "R11 stops after clear");
    chk_frame(k + 5, -1, -1, "R11 request ignored");
    chk(ack_cnt[1] == 0, "R11 no ack", ack_cnt[1], 0);

    // R3 request on boundary bit
    run_to(0);
    k = gpos / FRM_LEN;
    clr_acks();
    febe_req = 1; step(); febe_req = 0;
    run_frames_to(k + 3);
    chk_frame(k, -1, -1, "R3 boundary frame clean");
    chk_frame(k + 1, 6, -1, "R3 applied next boundary");
    chk(ack_cnt[3] == 1 && ack_pos[3] == (k + 2) * FRM_LEN, "R3 ack", ack_pos[3], (k + 2) * FRM_LEN);

    // R12 two types in the same frame
    run_to(120);
    k = gpos / FRM_LEN;
    clr_acks();
    par_req = 1; cbp_req = 1; step(); par_req = 0; cbp_req = 0;
    run_frames_to(k + 3);
    chk_frame(k + 1, 4, 5, "R12 shared frame");
    chk(ack_cnt[1] == 1 && ack_cnt[2] == 1 && ack_pos[1] == ack_pos[2], "R12 same-cycle acks",
        ack_pos[1], ack_pos[2]);

    // R2 payload never touched over the whole run
    begin
      int pf;
      pf = 0;
      for (int f = 0; f < MAXF; f++) pf += cnt[f][0] + cnt[f][9];
      chk(pf == 0, "R2 payload", pf, 0);
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule